// File: doc/BRIEF.md
# Programmable Tick Timer

The block is a processor tick timer built around two registers: a free-running 32-bit count register and a control register. The control register holds a period field, an interrupt-enable bit, an interrupt-pending bit and a two-bit action field. Software loads and reads both registers through a simple single-cycle register port. Each cycle in which the tick-enable input is high, and the timer is running, the full counter advances by one.

On every advance the block compares the low period-field bits of the incremented count with the period field. On a match it raises the pending flag, but only when interrupts are enabled. The action field then decides what happens to the count. It can leave counting alone, clear the count and restart, stop the count as a one-shot, or keep running continuously. The interrupt output is a level that follows the pending flag until software clears it.

Top module: `tick_timer`

## Requirements
- R1: After reset the count register reads 0, the control register reads 0, the timer is running and irq_o is low.
- R2: In each clock cycle with tick_i high, the timer running and no register write, the full 32-bit count increments by one and wraps from 0xFFFFFFFF to 0. In cycles with tick_i low the count holds.
- R3: A match occurs on an advance when bits 27:0 of the incremented count equal the period field (control bits 27:0). Count bits 31:28 take no part in the compare.
- R4: On a match with the enable bit (control bit 29) set, the pending bit (control bit 28) is set and irq_o is high from the next cycle. With the enable bit clear, a match leaves the pending bit unchanged, whether it is 0 or 1.
- R5: irq_o always equals the pending bit. Writing the control register with bit 28 clear drops irq_o in the next cycle.
- R6: With action 01 (restart) in control bits 31:30, a match loads 0 into the count, and counting continues from 0.
- R7: With action 10 (one-shot), a match loads the matching value into the count and stops the timer. Later ticks leave the count unchanged.
- R8: With action 11 (continuous), a match loads the matching value and counting continues. The next match comes only after bits 27:0 wrap round to the period again.
- R9: With action 00 (none), a match changes nothing in counting, and the count keeps incrementing.
- R10: A register write in the same cycle as tick_i takes the written value. The tick is dropped for that cycle, and no match is detected from it.
- R11: Writing the control register with an action other than 10 restarts a stopped timer. Writing action 10 leaves the run state as it is.
- R12: rd_data_o shows the count when rd_sel_i is 0 and the control register when rd_sel_i is 1, combinationally. Bits 31:30 hold the action, bit 29 the enable, bit 28 the pending flag and bits 27:0 the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count advance enable for this cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 count, 1 control |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read select: 0 count, 1 control |
| rd_data_o | output | 32 | Selected register value |
| irq_o | output | 1 | Timer interrupt level (pending flag) |

## Verification
Every effect of a tick or a write is due one clock edge later. The count, control register and irq_o are registered, and rd_data_o is a combinational view of them. Each bench task therefore drives its inputs for exactly one edge and samples 1 ns after that edge, well clear of both edges. Match cases are arranged so that the expected count and pending state after a known number of ticks can be worked out by hand. This includes the cycle just before the match and the one just after it.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int REG_W = 32;
  localparam int PER_W = 28;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'b00,
    ACT_RESTART = 2'b01,
    ACT_ONESHOT = 2'b10,
    ACT_CONT    = 2'b11
  } tt_act_e;

  typedef struct packed {
    tt_act_e          act;
    logic             ie;
    logic             ip;
    logic [PER_W-1:0] period;
  } tt_ctrl_t;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int W  = 32,
  parameter int PW = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  load_val_i,
  input  logic          adv_i,
  input  logic          clear_i,
  output logic [W-1:0]  cnt_o,
  output logic [PW-1:0] nxt_low_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_inc;

  assign cnt_inc   = cnt_q + W'(1);
  assign nxt_low_o = cnt_inc[PW-1:0];
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (adv_i)   cnt_q <= clear_i ? '0 : cnt_inc;
  end
endmodule

// File: rtl/tt_match.sv
module tt_match #(
  parameter int PW = 28
) (
  input  logic          adv_i,
  input  logic [PW-1:0] nxt_low_i,
  input  logic [PW-1:0] period_i,
  output logic          hit_o
);
  assign hit_o = adv_i && (nxt_low_i == period_i);
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             hit_i,
  output tt_ctrl_t         ctrl_o,
  output logic             run_o
);
  tt_ctrl_t ctrl_q, wr_ctrl;
  logic     run_q;

  assign wr_ctrl = tt_ctrl_t'(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q <= wr_ctrl;
    end else if (hit_i && ctrl_q.ie) begin
      ctrl_q.ip <= 1'b1;
    end
  end

  // one-shot stops; any non-one-shot action write resumes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b1;
    end else if (wr_i) begin
      if (wr_ctrl.act != ACT_ONESHOT) run_q <= 1'b1;
    end else if (hit_i && ctrl_q.act == ACT_ONESHOT) begin
      run_q <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign run_o  = run_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);
  tt_ctrl_t         ctrl_q;
  logic             run_q;
  logic [REG_W-1:0] cnt_q;
  logic [PER_W-1:0] nxt_low;
  logic             adv, hit, clr;

  // any write drops the tick for its cycle
  assign adv = tick_i && run_q && !wr_en_i;
  assign clr = hit && (ctrl_q.act == ACT_RESTART);

  tt_counter #(.W(REG_W), .PW(PER_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_en_i && !wr_sel_i),
    .load_val_i (wr_data_i),
    .adv_i      (adv),
    .clear_i    (clr),
    .cnt_o      (cnt_q),
    .nxt_low_o  (nxt_low)
  );

  tt_match #(.PW(PER_W)) u_match (
    .adv_i     (adv),
    .nxt_low_i (nxt_low),
    .period_i  (ctrl_q.period),
    .hit_o     (hit)
  );

  tt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i && wr_sel_i),
    .wr_data_i (wr_data_i),
    .hit_i     (hit),
    .ctrl_o    (ctrl_q),
    .run_o     (run_q)
  );

  assign rd_data_o = rd_sel_i ? REG_W'(ctrl_q) : cnt_q;
  assign irq_o     = ctrl_q.ip;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             irq_o,
  input logic [REG_W-1:0] cnt_q,
  input logic             run_q,
  input logic             hit,
  input tt_ctrl_t         ctrl_q
);
  p_irq_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && ctrl_q.ie |=> irq_o);

  p_irq_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !ctrl_q.ie |=> irq_o == $past(irq_o));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && ctrl_q.act == ACT_RESTART |=> cnt_q == '0);

  p_oneshot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && ctrl_q.act == ACT_ONESHOT |=> !run_q && cnt_q == REG_W'($past(cnt_q) + 1));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !(wr_en_i && !wr_sel_i) |=> $stable(cnt_q));

  p_cont_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && ctrl_q.act == ACT_CONT |=> run_q && cnt_q == REG_W'($past(cnt_q) + 1));

  p_wr_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_sel_i |=> cnt_q == $past(wr_data_i));

  p_resume_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i && wr_data_i[31:30] != 2'b10 |=> run_q);
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .cnt_q     (cnt_q),
  .run_q     (run_q),
  .hit       (hit),
  .ctrl_q    (ctrl_q)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_sel_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tick_timer uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one edge: drive, clock, settle 1 ns after the edge
  task automatic cyc(input logic tk, input logic we, input logic sel, input logic [31:0] d);
    tick_i = tk; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    @(posedge clk_i); #1;
    tick_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, '0);
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel_i = sel; #0.5; v = rd_data_o;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b0, v); chk("R1 count", v, 32'h0);
    rd(1'b1, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    ticks(1);
    rd(1'b0, v); chk("R1 running", v, 32'h1);
  endtask

  task automatic t_count();
    logic [31:0] v;
    cyc(1'b0, 1'b1, 1'b1, 32'h0FFF_FFFF);
    cyc(1'b0, 1'b1, 1'b0, 32'h0);
    for (int i = 0; i < 5; i++) begin
      ticks(1); cyc(1'b0, 1'b0, 1'b0, '0);
    end
    rd(1'b0, v); chk("R2 gapped ticks", v, 32'd5);
    cyc(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFE);
    ticks(3);
    rd(1'b0, v); chk("R2/R9 wrap past match in none", v, 32'h1);
    chk("R9 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    cyc(1'b0, 1'b1, 1'b1, 32'h6000_0004);
    cyc(1'b0, 1'b1, 1'b0, 32'h0);
    ticks(3);
    rd(1'b0, v); chk("R6 before match", v, 32'd3);
    chk("R4 no irq before match", {31'b0, irq_o}, 32'h0);
    ticks(1);
    rd(1'b0, v); chk("R6 cleared on match", v, 32'd0);
    chk("R4 irq on match", {31'b0, irq_o}, 32'h1);
    rd(1'b1, v); chk("R4 pending bit", v, 32'h7000_0004);
    cyc(1'b0, 1'b1, 1'b1, 32'h6000_0004);
    chk("R5 irq cleared", {31'b0, irq_o}, 32'h0);
    ticks(3);
    rd(1'b0, v); chk("R6 continues from 0", v, 32'd3);
  endtask

  task automatic t_noie();
    logic [31:0] v;
    cyc(1'b0, 1'b1, 1'b1, 32'h4000_0003);
    cyc(1'b0, 1'b1, 1'b0, 32'h0);
    ticks(3);
    rd(1'b0, v); chk("R4 match w/o enable restarts", v, 32'd0);
    chk("R4 pending stays 0", {31'b0, irq_o}, 32'h0);
    cyc(1'b0, 1'b1, 1'b1, 32'h5000_0003);
    chk("R5 irq follows written pending", {31'b0, irq_o}, 32'h1);
    ticks(3);
    chk("R4 pending stays 1", {31'b0, irq_o}, 32'h1);
    cyc(1'b0, 1'b1, 1'b1, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    cyc(1'b0, 1'b1, 1'b1, 32'hA000_0006);
    cyc(1'b0, 1'b1, 1'b0, 32'h0);
    ticks(10);
    rd(1'b0, v); chk("R7 stopped at period", v, 32'd6);
    chk("R7 irq", {31'b0, irq_o}, 32'h1);
    cyc(1'b0, 1'b1, 1'b1, 32'h8000_0006);
    ticks(3);
    rd(1'b0, v); chk("R11 one-shot write keeps stop", v, 32'd6);
    cyc(1'b0, 1'b1, 1'b1, 32'hC000_0006);
    ticks(2);
    rd(1'b0, v); chk("R11 resumed", v, 32'd8);
  endtask

  task automatic t_cont();
    logic [31:0] v;
    cyc(1'b0, 1'b1, 1'b1, 32'hE000_0005);
    cyc(1'b0, 1'b1, 1'b0, 32'h0FFF_FFF0);
    ticks(20);
    rd(1'b0, v); chk("R8 before wrap match", v, 32'h1000_0004);
    chk("R3 no early match", {31'b0, irq_o}, 32'h0);
    ticks(1);
    rd(1'b0, v); chk("R8 reaches match", v, 32'h1000_0005);
    chk("R3 upper bits ignored", {31'b0, irq_o}, 32'h1);
    ticks(1);
    rd(1'b0, v); chk("R8 keeps running", v, 32'h1000_0006);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    cyc(1'b0, 1'b1, 1'b1, 32'h6000_0002);
    cyc(1'b1, 1'b1, 1'b0, 32'h1);
    rd(1'b0, v); chk("R10 count write wins", v, 32'd1);
    chk("R10 no match from dropped tick", {31'b0, irq_o}, 32'h0);
    cyc(1'b1, 1'b1, 1'b1, 32'h6000_0002);
    rd(1'b0, v); chk("R10 ctrl write drops tick", v, 32'd1);
    ticks(1);
    rd(1'b0, v); chk("R10 then matches", v, 32'd0);
    chk("R10 irq after", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_read();
    logic [31:0] v;
    cyc(1'b0, 1'b1, 1'b1, 32'hA500_0123);
    rd(1'b1, v); chk("R12 ctrl layout", v, 32'hA500_0123);
    cyc(1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF);
    rd(1'b0, v); chk("R12 count view", v, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    t_reset();
    t_count();
    t_restart();
    t_noie();
    t_oneshot();
    t_cont();
    t_prio();
    t_read();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule